// File: doc/BRIEF.md
# Integer ALU with function decode

A purely combinational arithmetic, logic and shift unit for a compact load/store processor. Each cycle it receives a 6-bit primary opcode, a 6-bit function field, a shift-amount field, two register operands and a half-width immediate. It decodes the opcode and the function field together to pick one operation. It returns the result, a signed-overflow indication and a flag for encodings it does not recognise.

The opcode chooses between the register form (opcode 0, where the function field names the operation) and the immediate forms. Arithmetic immediates are sign-extended. Logical immediates are zero-extended. The overflow flag is only reported; acting on it belongs to the surrounding pipeline. The block has no storage and no handshake. Its outputs follow its inputs within the same cycle, so a valid/ready wrapper is not part of this unit, and back-pressure is a matter for the stage that holds the operands.

The datapath width is the parameter `XLEN`, which defaults to 32. The immediate is `XLEN/2` bits wide. The shift-amount field is `log2(XLEN)` bits wide.

Top module: `int_alu`

## Requirements
- R1: With opcode 0, function codes 32 and 33 give src_a + src_b, and 34 and 35 give src_a - src_b, each modulo 2^XLEN.
- R2: With opcode 0, function codes 36, 37, 38 and 39 give AND, OR, XOR and NOR of src_a and src_b. None of them ever raises overflow.
- R3: Set-less-than (opcode 0 with function 42, and opcode 10 against the sign-extended immediate) gives 1 when src_a is less than the second operand as signed values, and 0 otherwise.
- R4: Fixed shifts (opcode 0 with function 0 = left logical, 2 = right logical, 3 = right arithmetic) shift src_b by shamt. The right arithmetic shift replicates the sign bit of src_b.
- R5: Variable shifts (opcode 0 with function 4 = left logical, 6 = right logical, 7 = right arithmetic) shift src_b by the low log2(XLEN) bits of src_a. The upper bits of src_a are ignored.
- R6: Opcodes 8 and 9 give src_a plus the sign-extended immediate.
- R7: Opcodes 12, 13 and 14 give AND, OR and XOR of src_a with the zero-extended immediate.
- R8: Opcode 15 places the immediate in the upper half of the result and zeros in the lower half.
- R9: The overflow flag is set when the signed result of function 32 or 34 or of opcode 8 does not fit in XLEN bits. Function codes 33 and 35 and opcode 9 never set it.
- R10: Any opcode/function pair not listed above drives illegal_o high, a zero result and no overflow. Every listed pair drives illegal_o low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opc_i | input | 6 | Primary opcode |
| fn_i | input | 6 | Function field, used when the opcode is 0 |
| shamt_i | input | log2(XLEN) | Shift count for the fixed shifts |
| src_a_i | input | XLEN | First register operand |
| src_b_i | input | XLEN | Second register operand |
| imm_i | input | XLEN/2 | Immediate field |
| result_o | output | XLEN | Operation result |
| ovf_o | output | 1 | Signed overflow of the signed add/subtract forms |
| illegal_o | output | 1 | Unrecognised opcode/function pair |

## Verification
The bench builds the unit with XLEN = 8, which makes the immediate 4 bits wide and the shift count 3 bits wide. At that width, every value of src_a is applied against a dense stride of src_b values and every immediate value, for every legal operation and for a set of unused encodings. This brings within reach every overflow boundary, every sign-extension case of the immediate, and every shift distance, including variable counts whose upper bits must be ignored.

// File: rtl/alu_pkg.sv
package alu_pkg;

  localparam int OPC_W = 6;
  localparam int FN_W  = 6;

  // primary opcodes
  localparam logic [OPC_W-1:0] OPC_REG   = 6'd0;
  localparam logic [OPC_W-1:0] OPC_ADDI  = 6'd8;
  localparam logic [OPC_W-1:0] OPC_ADDIU = 6'd9;
  localparam logic [OPC_W-1:0] OPC_SLTI  = 6'd10;
  localparam logic [OPC_W-1:0] OPC_ANDI  = 6'd12;
  localparam logic [OPC_W-1:0] OPC_ORI   = 6'd13;
  localparam logic [OPC_W-1:0] OPC_XORI  = 6'd14;
  localparam logic [OPC_W-1:0] OPC_LUI   = 6'd15;

  // function codes of the register form
  localparam logic [FN_W-1:0] FN_SLL  = 6'd0;
  localparam logic [FN_W-1:0] FN_SRL  = 6'd2;
  localparam logic [FN_W-1:0] FN_SRA  = 6'd3;
  localparam logic [FN_W-1:0] FN_SLLV = 6'd4;
  localparam logic [FN_W-1:0] FN_SRLV = 6'd6;
  localparam logic [FN_W-1:0] FN_SRAV = 6'd7;
  localparam logic [FN_W-1:0] FN_ADD  = 6'd32;
  localparam logic [FN_W-1:0] FN_ADDU = 6'd33;
  localparam logic [FN_W-1:0] FN_SUB  = 6'd34;
  localparam logic [FN_W-1:0] FN_SUBU = 6'd35;
  localparam logic [FN_W-1:0] FN_AND  = 6'd36;
  localparam logic [FN_W-1:0] FN_OR   = 6'd37;
  localparam logic [FN_W-1:0] FN_XOR  = 6'd38;
  localparam logic [FN_W-1:0] FN_NOR  = 6'd39;
  localparam logic [FN_W-1:0] FN_SLT  = 6'd42;

  typedef enum logic [3:0] {
    K_NONE, K_ADD, K_SUB, K_AND, K_OR, K_XOR, K_NOR,
    K_SLT, K_LUI, K_SLL, K_SRL, K_SRA
  } alu_kind_e;

  typedef struct packed {
    alu_kind_e kind;
    logic      use_imm;   // second operand from the immediate
    logic      imm_sext;  // sign- rather than zero-extend it
    logic      var_shift; // shift count from src_a
    logic      trap_ovf;  // report signed overflow
    logic      illegal;
  } alu_ctl_t;

endpackage

// File: rtl/alu_decode.sv
module alu_decode
  import alu_pkg::*;
(
  input  logic [OPC_W-1:0] opc_i,
  input  logic [FN_W-1:0]  fn_i,
  output alu_ctl_t         ctl_o
);

  always_comb begin
    ctl_o = '0;
    ctl_o.kind = K_NONE;
    unique case (opc_i)
      OPC_REG: begin
        unique case (fn_i)
          FN_SLL:  ctl_o.kind = K_SLL;
          FN_SRL:  ctl_o.kind = K_SRL;
          FN_SRA:  ctl_o.kind = K_SRA;
          FN_SLLV: begin ctl_o.kind = K_SLL; ctl_o.var_shift = 1'b1; end
          FN_SRLV: begin ctl_o.kind = K_SRL; ctl_o.var_shift = 1'b1; end
          FN_SRAV: begin ctl_o.kind = K_SRA; ctl_o.var_shift = 1'b1; end
          FN_ADD:  begin ctl_o.kind = K_ADD; ctl_o.trap_ovf = 1'b1; end
          FN_ADDU: ctl_o.kind = K_ADD;
          FN_SUB:  begin ctl_o.kind = K_SUB; ctl_o.trap_ovf = 1'b1; end
          FN_SUBU: ctl_o.kind = K_SUB;
          FN_AND:  ctl_o.kind = K_AND;
          FN_OR:   ctl_o.kind = K_OR;
          FN_XOR:  ctl_o.kind = K_XOR;
          FN_NOR:  ctl_o.kind = K_NOR;
          FN_SLT:  ctl_o.kind = K_SLT;
          default: ctl_o.illegal = 1'b1;
        endcase
      end
      OPC_ADDI: begin
        ctl_o.kind = K_ADD; ctl_o.use_imm = 1'b1;
        ctl_o.imm_sext = 1'b1; ctl_o.trap_ovf = 1'b1;
      end
      OPC_ADDIU: begin
        ctl_o.kind = K_ADD; ctl_o.use_imm = 1'b1; ctl_o.imm_sext = 1'b1;
      end
      OPC_SLTI: begin
        ctl_o.kind = K_SLT; ctl_o.use_imm = 1'b1; ctl_o.imm_sext = 1'b1;
      end
      OPC_ANDI: begin ctl_o.kind = K_AND; ctl_o.use_imm = 1'b1; end
      OPC_ORI:  begin ctl_o.kind = K_OR;  ctl_o.use_imm = 1'b1; end
      OPC_XORI: begin ctl_o.kind = K_XOR; ctl_o.use_imm = 1'b1; end
      OPC_LUI:  ctl_o.kind = K_LUI;
      default:  ctl_o.illegal = 1'b1;
    endcase
  end

endmodule

// File: rtl/alu_opnd.sv
module alu_opnd
  import alu_pkg::*;
#(
  parameter int XLEN = 32,
  localparam int IMM_W = XLEN / 2
) (
  input  logic [XLEN-1:0]  src_b_i,
  input  logic [IMM_W-1:0] imm_i,
  input  alu_ctl_t         ctl_i,
  output logic [XLEN-1:0]  opb_o
);

  logic [XLEN-1:0] imm_ext;

  always_comb begin
    if (ctl_i.imm_sext)
      imm_ext = {{(XLEN-IMM_W){imm_i[IMM_W-1]}}, imm_i};
    else
      imm_ext = {{(XLEN-IMM_W){1'b0}}, imm_i};
    opb_o = ctl_i.use_imm ? imm_ext : src_b_i;
  end

endmodule

// File: rtl/alu_shift.sv
module alu_shift
  import alu_pkg::*;
#(
  parameter int XLEN = 32,
  localparam int SH_W = $clog2(XLEN)
) (
  input  logic [XLEN-1:0] data_i,
  input  logic [SH_W-1:0] cnt_i,
  input  alu_kind_e       kind_i,
  output logic [XLEN-1:0] out_o
);

  always_comb begin
    unique case (kind_i)
      K_SLL:   out_o = data_i << cnt_i;
      K_SRA:   out_o = $unsigned($signed(data_i) >>> cnt_i);
      default: out_o = data_i >> cnt_i;
    endcase
  end

endmodule

// File: rtl/alu_arith.sv
module alu_arith
  import alu_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  alu_kind_e       kind_i,
  input  logic            trap_ovf_i,
  output logic [XLEN-1:0] out_o,
  output logic            ovf_o
);

  localparam int MSB = XLEN - 1;

  logic            is_sub;
  logic [XLEN-1:0] b_eff;
  logic [XLEN-1:0] sum;
  logic            slt;

  always_comb begin
    is_sub = (kind_i == K_SUB);
    b_eff  = is_sub ? ~b_i : b_i;
    sum    = a_i + b_eff + {{(XLEN-1){1'b0}}, is_sub};
    slt    = ($signed(a_i) < $signed(b_i));
    unique case (kind_i)
      K_ADD, K_SUB: out_o = sum;
      K_AND:        out_o = a_i & b_i;
      K_OR:         out_o = a_i | b_i;
      K_XOR:        out_o = a_i ^ b_i;
      K_NOR:        out_o = ~(a_i | b_i);
      K_SLT:        out_o = {{(XLEN-1){1'b0}}, slt};
      default:      out_o = '0;
    endcase
    // operands of equal effective sign whose sum flips sign
    ovf_o = trap_ovf_i && (kind_i == K_ADD || kind_i == K_SUB)
            && (a_i[MSB] == b_eff[MSB]) && (sum[MSB] != a_i[MSB]);
  end

endmodule

// File: rtl/int_alu.sv
module int_alu
  import alu_pkg::*;
#(
  parameter int XLEN = 32,
  localparam int IMM_W = XLEN / 2,
  localparam int SH_W  = $clog2(XLEN)
) (
  input  logic [5:0]       opc_i,
  input  logic [5:0]       fn_i,
  input  logic [SH_W-1:0]  shamt_i,
  input  logic [XLEN-1:0]  src_a_i,
  input  logic [XLEN-1:0]  src_b_i,
  input  logic [IMM_W-1:0] imm_i,
  output logic [XLEN-1:0]  result_o,
  output logic             ovf_o,
  output logic             illegal_o
);

  alu_ctl_t        ctl;
  logic [XLEN-1:0] opb;
  logic [SH_W-1:0] sh_cnt;
  logic [XLEN-1:0] sh_out;
  logic [XLEN-1:0] ar_out;
  logic            ar_ovf;

  alu_decode u_dec (.opc_i(opc_i), .fn_i(fn_i), .ctl_o(ctl));

  alu_opnd #(.XLEN(XLEN)) u_opnd (
    .src_b_i(src_b_i), .imm_i(imm_i), .ctl_i(ctl), .opb_o(opb)
  );

  assign sh_cnt = ctl.var_shift ? src_a_i[SH_W-1:0] : shamt_i;

  alu_shift #(.XLEN(XLEN)) u_shift (
    .data_i(src_b_i), .cnt_i(sh_cnt), .kind_i(ctl.kind), .out_o(sh_out)
  );

  alu_arith #(.XLEN(XLEN)) u_arith (
    .a_i(src_a_i), .b_i(opb), .kind_i(ctl.kind), .trap_ovf_i(ctl.trap_ovf),
    .out_o(ar_out), .ovf_o(ar_ovf)
  );

  always_comb begin
    unique case (ctl.kind)
      K_SLL, K_SRL, K_SRA: result_o = sh_out;
      K_LUI:               result_o = {imm_i, {(XLEN-IMM_W){1'b0}}};
      K_NONE:              result_o = '0;
      default:             result_o = ar_out;
    endcase
    ovf_o     = ar_ovf;
    illegal_o = ctl.illegal;
  end

endmodule

// File: rtl/int_alu_checker.sv
module int_alu_checker #(
  parameter int XLEN = 32,
  localparam int IMM_W = XLEN / 2,
  localparam int SH_W  = $clog2(XLEN)
) (
  input logic [5:0]       opc_i,
  input logic [5:0]       fn_i,
  input logic [SH_W-1:0]  shamt_i,
  input logic [XLEN-1:0]  src_a_i,
  input logic [XLEN-1:0]  src_b_i,
  input logic [IMM_W-1:0] imm_i,
  input logic [XLEN-1:0]  result_o,
  input logic             ovf_o,
  input logic             illegal_o
);

  logic known;
  logic is_reg;

  always_comb begin
    known  = !$isunknown({opc_i, fn_i, illegal_o, ovf_o});
    is_reg = (opc_i == 6'd0);
    if (known) begin
      p_illegal_quiet_r10: assert (!illegal_o || (result_o == '0 && !ovf_o))
        else $error("illegal encoding produced data or overflow");
      p_unknown_fn_flag_r10: assert (!(is_reg && (fn_i == 6'd1 || fn_i == 6'd40)) || illegal_o)
        else $error("unused function code not flagged");
      p_unsigned_no_ovf_r9: assert (!((is_reg && (fn_i == 6'd33 || fn_i == 6'd35)) || opc_i == 6'd9) || !ovf_o)
        else $error("unsigned add/sub raised overflow");
      p_logic_no_ovf_r2: assert (!((is_reg && fn_i >= 6'd36 && fn_i <= 6'd39) ||
                                    (opc_i >= 6'd12 && opc_i <= 6'd14)) || !ovf_o)
        else $error("bitwise operation raised overflow");
      p_lui_layout_r8: assert (opc_i != 6'd15 ||
                                result_o == {imm_i, {(XLEN-IMM_W){1'b0}}})
        else $error("upper-immediate layout wrong");
      p_slt_bool_r3: assert (!(opc_i == 6'd10 || (is_reg && fn_i == 6'd42)) ||
                              result_o[XLEN-1:1] == '0)
        else $error("set-less-than result not 0/1");
    end
  end

endmodule

bind int_alu int_alu_checker #(.XLEN(XLEN)) u_chk (
  .opc_i(opc_i), .fn_i(fn_i), .shamt_i(shamt_i), .src_a_i(src_a_i),
  .src_b_i(src_b_i), .imm_i(imm_i), .result_o(result_o), .ovf_o(ovf_o),
  .illegal_o(illegal_o)
);

// File: tb/int_alu_bench.sv
module int_alu_bench;

  localparam int W  = 8;
  localparam int IW = W / 2;
  localparam int SW = $clog2(W);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [5:0]    opc = '0;
  logic [5:0]    fn = '0;
  logic [SW-1:0] shamt = '0;
  logic [W-1:0]  a = '0;
  logic [W-1:0]  b = '0;
  logic [IW-1:0] imm = '0;
  logic [W-1:0]  res;
  logic          ovf;
  logic          ill;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  int_alu #(.XLEN(W)) u_int_alu (
    .opc_i(opc), .fn_i(fn), .shamt_i(shamt), .src_a_i(a), .src_b_i(b),
    .imm_i(imm), .result_o(res), .ovf_o(ovf), .illegal_o(ill)
  );

  function automatic string req_of(input logic [5:0] o, input logic [5:0] f);
    if (o == 0) begin
      case (f)
        0, 2, 3: return "R4";
        4, 6, 7: return "R5";
        32, 33, 34, 35: return "R1/R9";
        36, 37, 38, 39: return "R2";
        42: return "R3";
        default: return "R10";
      endcase
    end
    case (o)
      8, 9: return "R6/R9";
      10: return "R3";
      12, 13, 14: return "R7";
      15: return "R8";
      default: return "R10";
    endcase
  endfunction

  // expected {illegal, overflow, result}
  function automatic logic [W+1:0] model(input logic [5:0] o, input logic [5:0] f,
                                         input logic [W-1:0] x, input logic [W-1:0] y,
                                         input logic [IW-1:0] im, input logic [SW-1:0] s);
    int sx, sy, si, zi, t, lim;
    logic [W-1:0] r;
    logic v, il;
    sx = $signed(x); sy = $signed(y);
    si = $signed(im); zi = int'(im);
    lim = 1 << (W - 1);
    r = '0; v = 1'b0; il = 1'b0;
    if (o == 0) begin
      case (f)
        0: r = W'(int'(y) * (1 << s));
        2: r = W'(int'(y) / (1 << s));
        3: r = W'(sy >>> s);
        4: r = W'(int'(y) * (1 << (x % W)));
        6: r = W'(int'(y) / (1 << (x % W)));
        7: r = W'(sy >>> (x % W));
        32, 33: begin t = sx + sy; r = W'(t); v = (f == 32) && (t >= lim || t < -lim); end
        34, 35: begin t = sx - sy; r = W'(t); v = (f == 34) && (t >= lim || t < -lim); end
        36: r = x & y;
        37: r = x | y;
        38: r = x ^ y;
        39: r = ~(x | y);
        42: r = (sx < sy) ? W'(1) : W'(0);
        default: il = 1'b1;
      endcase
    end else begin
      case (o)
        8, 9: begin t = sx + si; r = W'(t); v = (o == 8) && (t >= lim || t < -lim); end
        10: r = (sx < si) ? W'(1) : W'(0);
        12: r = x & W'(zi);
        13: r = x | W'(zi);
        14: r = x ^ W'(zi);
        15: r = W'(zi * (1 << (W - IW)));
        default: il = 1'b1;
      endcase
    end
    return {il, v, r};
  endfunction

  task automatic check(input string tag);
    logic [W+1:0] exp;
    exp = model(opc, fn, a, b, imm, shamt);
    n_checks++;
    if ({ill, ovf, res} !== exp) begin
      n_fail++;
      if (n_fail <= 25)
        $display("FAIL %s opc=%0d fn=%0d a=%h b=%h imm=%h sh=%0d: got ill=%b ovf=%b res=%h, expected ill=%b ovf=%b res=%h",
                 tag, opc, fn, a, b, imm, shamt, ill, ovf, res, exp[W+1], exp[W], exp[W-1:0]);
    end
  endtask

  task automatic sweep(input logic [5:0] o, input logic [5:0] f);
    opc = o; fn = f;
    for (int i = 0; i < 256; i++) begin
      for (int j = 0; j < 256; j += 5) begin
        a = W'(i); b = W'(j);
        imm = IW'(j + i);
        shamt = SW'(i + j / 5);
        #1;
        check(req_of(o, f));
      end
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired: got hang, expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // idle inputs: shift-left of zero by zero, legal, no overflow
    check("R4 idle");
    // boundary points: largest positive plus one, most negative minus one
    opc = 0; fn = 32; a = 8'h7f; b = 8'h01; #1; check("R9 add overflow");
    fn = 33; #1; check("R9 addu no overflow");
    fn = 34; a = 8'h80; b = 8'h01; #1; check("R9 sub overflow");
    fn = 35; #1; check("R9 subu no overflow");
    opc = 8; a = 8'h80; imm = 4'h8; #1; check("R6 addi sign-extended overflow");
    opc = 9; #1; check("R6 addiu no overflow");
    opc = 12; a = 8'hff; imm = 4'hf; #1; check("R7 andi zero-extended");
    opc = 0; fn = 7; a = 8'hf9; b = 8'h80; #1; check("R5 srav upper count bits ignored");
    for (int o = 0; o < 64; o++) begin
      if (o == 0) begin
        for (int f = 0; f < 64; f++) begin
          if (f inside {0, 2, 3, 4, 6, 7, 32, 33, 34, 35, 36, 37, 38, 39, 42, 1, 5, 40})
            sweep(6'(o), 6'(f));
        end
      end else if (o inside {8, 9, 10, 12, 13, 14, 15, 11, 16, 63}) begin
        sweep(6'(o), 6'd0);
      end
    end
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

endmodule